// File: doc/BRIEF.md
# Serial Channel Mode and Trigger Control

This block sits beside the shifter of one channel of a multi-mode serial unit that can run as a clocked synchronous link, an asynchronous receiver/transmitter or a simplified two-wire bus. It holds the channel's 16-bit configuration word. Software writes that word one byte at a time. From the word the block picks one of two prescaler enables as the operation clock. It then produces a transfer-clock enable, either from a programmable even divider or from a synchronized external serial clock.

The block also arms a transfer when a start request arrives. It issues a single-cycle start pulse as soon as the selected trigger is met. The trigger is either the request alone or a later falling edge on the receive line. The receive line is synchronized and can be inverted when the channel is in the asynchronous mode. While the channel runs, the configuration is frozen, except for its least significant bit.

Top module: `sch_mode_ctrl`

## Requirements
- R1: After reset the configuration word reads 16'h0020 (upper byte 00h, lower byte 20h), and start_pulse and tclk_ce are low.
- R2: Reserved positions hold fixed values whatever is written. Upper-byte bits 5:1 and lower-byte bits 7, 4 and 3 read 0, and lower-byte bit 5 reads 1. Writable fields: upper bit 7 = operation clock select, upper bit 6 = external clock select, upper bit 0 = edge trigger select, lower bit 6 = receive invert, lower bits 2:1 = mode (00 synchronous, 01 asynchronous, 10 two-wire), lower bit 0 = spare mode bit.
- R3: While ch_run is 1, upper-byte writes (wr_hi=1) leave the upper byte unchanged, and lower-byte writes leave lower bits 7:1 unchanged.
- R4: The operation clock enable is pre_ce1 when upper bit 7 is 1 and pre_ce0 when it is 0. tclk_ce is high only in cycles where the selected enable is high.
- R5: With upper bit 6 = 0 and ch_run = 1, tclk_ce pulses once every 2*(N+1) operation clock enables, where N is div_ratio. The first pulse comes on the (2N+2)-th enable after ch_run rises. tclk_ce stays low while ch_run is 0.
- R6: With upper bit 6 = 1, each rising edge on sck_in gives exactly one tclk_ce pulse. The pulse falls in the first cycle with an operation clock enable after the edge has passed a two-flop synchronizer: with the enable held high, that is the cycle after the second clock edge that samples the new level. Falling edges give none.
- R7: With upper bit 0 = 0, a start_req sampled while ch_run = 1 gives start_pulse high for exactly one cycle, in the cycle after the second clock edge following the request. A start_req sampled while ch_run = 0 never produces a pulse.
- R8: With upper bit 0 = 1, an armed request waits for a falling edge of the conditioned receive data. start_pulse rises in the cycle after the third clock edge following the pin change. An edge detected in the same cycle as the request does not start the transfer.
- R9: Dropping ch_run clears a pending armed request, so a later receive edge produces no start pulse.
- R10: rxd_out is rxd_in after two clock edges, inverted when lower bit 6 is 1 and the mode field is 01. In any other mode, rxd_out is not inverted.
- R11: While ch_run is 1, lower-byte writes still update lower bit 0.
- R12: With inversion active and the edge trigger selected, a rising edge on the rxd_in pin is the valid trigger edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Byte write strobe for the configuration word |
| wr_hi | input | 1 | Byte select: 1 = upper byte, 0 = lower byte |
| wr_data | input | 8 | Byte write data |
| div_ratio | input | DIV_W (7) | Divider field N taken from the data register |
| ch_run | input | 1 | Channel enable status |
| start_req | input | 1 | Start request strobe |
| pre_ce0 | input | 1 | Prescaler clock enable 0 |
| pre_ce1 | input | 1 | Prescaler clock enable 1 |
| sck_in | input | 1 | External serial clock pin |
| rxd_in | input | 1 | Receive data pin |
| mode_rd | output | 16 | Configuration word read-back |
| tclk_ce | output | 1 | Transfer clock enable |
| start_pulse | output | 1 | One-cycle transfer start |
| rxd_out | output | 1 | Synchronized, conditioned receive data |

## Verification
Two functions can coincide in one cycle: arming by start_req, and detection of a falling receive edge. The bench times start_req to be sampled on exactly the clock edge at which the synchronized falling edge is first visible. It then requires that no start pulse appears while the line stays low, and that the next genuine falling edge does start the transfer. A second overlap comes from byte writes issued while ch_run is high. There, the read-back word must show only the spare bit moving.

// File: rtl/sch_pkg.sv
package sch_pkg;

  localparam int unsigned BYTE_W = 8;

  // reset images of the two configuration bytes
  localparam logic [BYTE_W-1:0] HI_RST = 8'h00;
  localparam logic [BYTE_W-1:0] LO_RST = 8'h20;

  // writable bits while stopped
  localparam logic [BYTE_W-1:0] HI_WMASK = 8'hC1;
  localparam logic [BYTE_W-1:0] LO_WMASK = 8'h47;

  // writable bits while running
  localparam logic [BYTE_W-1:0] HI_RUN_MASK = 8'h00;
  localparam logic [BYTE_W-1:0] LO_RUN_MASK = 8'h01;

  // field positions
  localparam int unsigned HI_OPCLK  = 7;
  localparam int unsigned HI_EXTCLK = 6;
  localparam int unsigned HI_TRIG   = 0;
  localparam int unsigned LO_RXINV  = 6;
  localparam int unsigned LO_MODE   = 1;

  typedef enum logic [1:0] {
    MODE_SYNC  = 2'b00,
    MODE_ASYNC = 2'b01,
    MODE_TWIRE = 2'b10,
    MODE_RSVD  = 2'b11
  } sch_mode_e;

endpackage

// File: rtl/sch_sync.sv
module sch_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  generate
    if (STAGES == 1) begin : g_single
      assign sh_d = d;
    end else begin : g_chain
      assign sh_d = {sh_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= {STAGES{RST_VAL}};
    else        sh_q <= sh_d;
  end

  assign q = sh_q[STAGES-1];

endmodule

// File: rtl/sch_mode_reg.sv
module sch_mode_reg
  import sch_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              ch_run,
  output logic [15:0]       mode_rd,
  output logic              opclk_sel,
  output logic              ext_clk,
  output logic              edge_trig,
  output logic              rx_inv,
  output logic [1:0]        mode_fld
);

  logic [BYTE_W-1:0] hi_q, hi_d;
  logic [BYTE_W-1:0] lo_q, lo_d;
  logic [BYTE_W-1:0] hi_msk, lo_msk;

  always_comb begin
    hi_msk = ch_run ? HI_RUN_MASK : HI_WMASK;
    lo_msk = ch_run ? LO_RUN_MASK : LO_WMASK;
    hi_d   = hi_q;
    lo_d   = lo_q;
    if (wr_en) begin
      if (wr_hi) hi_d = (hi_q & ~hi_msk) | (wr_data & hi_msk);
      else       lo_d = (lo_q & ~lo_msk) | (wr_data & lo_msk);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= HI_RST;
      lo_q <= LO_RST;
    end else begin
      hi_q <= hi_d;
      lo_q <= lo_d;
    end
  end

  assign mode_rd   = {hi_q, lo_q};
  assign opclk_sel = hi_q[HI_OPCLK];
  assign ext_clk   = hi_q[HI_EXTCLK];
  assign edge_trig = hi_q[HI_TRIG];
  assign rx_inv    = lo_q[LO_RXINV];
  assign mode_fld  = lo_q[LO_MODE +: 2];

endmodule

// File: rtl/sch_tclk_gen.sv
module sch_tclk_gen #(
  parameter int unsigned DIV_W       = 7,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ch_run,
  input  logic             opclk_sel,
  input  logic             ext_clk,
  input  logic             pre_ce0,
  input  logic             pre_ce1,
  input  logic [DIV_W-1:0] div_ratio,
  input  logic             sck_in,
  output logic             tclk_ce
);

  localparam int unsigned CNT_W = DIV_W + 1;

  logic             op_ce;
  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             div_hit;
  logic             sck_s;
  logic             sck_e_q, sck_e_d;
  logic             ext_rise;

  assign op_ce = opclk_sel ? pre_ce1 : pre_ce0;
  assign limit = {div_ratio, 1'b1};

  sch_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sck_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (sck_in),
    .q     (sck_s)
  );

  always_comb begin
    cnt_d = cnt_q;
    if (!ch_run || ext_clk)  cnt_d = '0;
    else if (op_ce)          cnt_d = (cnt_q == limit) ? '0 : cnt_q + CNT_W'(1);
    sck_e_d = op_ce ? sck_s : sck_e_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      sck_e_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      sck_e_q <= sck_e_d;
    end
  end

  assign div_hit  = op_ce && (cnt_q == limit);
  assign ext_rise = op_ce && sck_s && !sck_e_q;
  assign tclk_ce  = ch_run && (ext_clk ? ext_rise : div_hit);

endmodule

// File: rtl/sch_start_ctrl.sv
module sch_start_ctrl #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ch_run,
  input  logic edge_trig,
  input  logic rx_invert,
  input  logic start_req,
  input  logic rxd_in,
  output logic start_pulse,
  output logic rxd_out
);

  logic rx_s;
  logic rx_cond;
  logic rx_prev_q;
  logic rx_fall;
  logic trig_ok;
  logic armed_q, armed_d;
  logic pulse_q, pulse_d;

  sch_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rx_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (rxd_in),
    .q     (rx_s)
  );

  assign rx_cond = rx_s ^ rx_invert;
  assign rx_fall = rx_prev_q && !rx_cond;
  assign trig_ok = edge_trig ? rx_fall : 1'b1;

  always_comb begin
    armed_d = ch_run && (start_req || (armed_q && !trig_ok));
    pulse_d = ch_run && armed_q && trig_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_prev_q <= 1'b1;
      armed_q   <= 1'b0;
      pulse_q   <= 1'b0;
    end else begin
      rx_prev_q <= rx_cond;
      armed_q   <= armed_d;
      pulse_q   <= pulse_d;
    end
  end

  assign start_pulse = pulse_q;
  assign rxd_out     = rx_cond;

endmodule

// File: rtl/sch_mode_ctrl.sv
module sch_mode_ctrl
  import sch_pkg::*;
#(
  parameter int unsigned DIV_W       = 7,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [DIV_W-1:0]  div_ratio,
  input  logic              ch_run,
  input  logic              start_req,
  input  logic              pre_ce0,
  input  logic              pre_ce1,
  input  logic              sck_in,
  input  logic              rxd_in,
  output logic [15:0]       mode_rd,
  output logic              tclk_ce,
  output logic              start_pulse,
  output logic              rxd_out
);

  logic [1:0] rst_sh_q;
  logic       rst_i_n;
  logic       opclk_sel, ext_clk, edge_trig, rx_inv;
  logic [1:0] mode_fld;
  logic       rx_invert;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh_q <= 2'b00;
    else        rst_sh_q <= {rst_sh_q[0], 1'b1};
  end
  assign rst_i_n = rst_sh_q[1];

  sch_mode_reg u_reg (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .wr_en     (wr_en),
    .wr_hi     (wr_hi),
    .wr_data   (wr_data),
    .ch_run    (ch_run),
    .mode_rd   (mode_rd),
    .opclk_sel (opclk_sel),
    .ext_clk   (ext_clk),
    .edge_trig (edge_trig),
    .rx_inv    (rx_inv),
    .mode_fld  (mode_fld)
  );

  assign rx_invert = rx_inv && (sch_mode_e'(mode_fld) == MODE_ASYNC);

  sch_tclk_gen #(.DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)) u_tclk (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .ch_run    (ch_run),
    .opclk_sel (opclk_sel),
    .ext_clk   (ext_clk),
    .pre_ce0   (pre_ce0),
    .pre_ce1   (pre_ce1),
    .div_ratio (div_ratio),
    .sck_in    (sck_in),
    .tclk_ce   (tclk_ce)
  );

  sch_start_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_start (
    .clk         (clk),
    .rst_n       (rst_i_n),
    .ch_run      (ch_run),
    .edge_trig   (edge_trig),
    .rx_invert   (rx_invert),
    .start_req   (start_req),
    .rxd_in      (rxd_in),
    .start_pulse (start_pulse),
    .rxd_out     (rxd_out)
  );

endmodule

// File: rtl/sch_mode_ctrl_chk.sv
module sch_mode_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        wr_hi,
  input logic        ch_run,
  input logic        pre_ce0,
  input logic        pre_ce1,
  input logic [15:0] mode_rd,
  input logic        tclk_ce,
  input logic        start_pulse
);

  // R3: upper byte frozen while running
  p_lock_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_run && wr_en && wr_hi) |=> $stable(mode_rd[15:8]));

  // R3: lower byte frozen except bit 0 while running
  p_lock_lo_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_run && wr_en && !wr_hi) |=> (mode_rd[7:1] == $past(mode_rd[7:1])));

  // R4: transfer clock only on selected prescaler enable
  p_ce_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tclk_ce |-> (mode_rd[15] ? pre_ce1 : pre_ce0));

  // R5: transfer clock enables never back to back
  p_tclk_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tclk_ce |=> !tclk_ce);

  // R7: start pulse is one cycle wide
  p_pulse_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !start_pulse);

  // R9: start pulse only follows a running cycle
  p_pulse_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> $past(ch_run));

endmodule

bind sch_mode_ctrl sch_mode_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .wr_hi       (wr_hi),
  .ch_run      (ch_run),
  .pre_ce0     (pre_ce0),
  .pre_ce1     (pre_ce1),
  .mode_rd     (mode_rd),
  .tclk_ce     (tclk_ce),
  .start_pulse (start_pulse)
);

// File: tb/tb_sch_mode_ctrl.sv
`timescale 1ns/1ps
module tb_sch_mode_ctrl;

  logic        clk;
  logic        rst_n;
  logic        wr_en, wr_hi;
  logic [7:0]  wr_data;
  logic [6:0]  div_ratio;
  logic        ch_run, start_req, pre_ce0, pre_ce1, sck_in, rxd_in;
  logic [15:0] mode_rd;
  logic        tclk_ce, start_pulse, rxd_out;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  sch_mode_ctrl dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_hi(wr_hi), .wr_data(wr_data),
    .div_ratio(div_ratio), .ch_run(ch_run), .start_req(start_req),
    .pre_ce0(pre_ce0), .pre_ce1(pre_ce1), .sck_in(sck_in), .rxd_in(rxd_in),
    .mode_rd(mode_rd), .tclk_ce(tclk_ce), .start_pulse(start_pulse), .rxd_out(rxd_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic hi, input logic [7:0] d);
    wr_en = 1'b1; wr_hi = hi; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic t_reset();
    check("R1 word", mode_rd, 16'h0020);
    check("R1 pulse", {15'd0, start_pulse}, 16'd0);
    check("R1 tclk", {15'd0, tclk_ce}, 16'd0);
  endtask

  task automatic t_reserved();
    wr(1'b1, 8'hFF);
    check("R2 hi ones", {8'd0, mode_rd[15:8]}, 16'h00C1);
    wr(1'b0, 8'h00);
    check("R2 lo zeros", {8'd0, mode_rd[7:0]}, 16'h0020);
    wr(1'b0, 8'hFF);
    check("R2 lo ones", {8'd0, mode_rd[7:0]}, 16'h0067);
    wr(1'b1, 8'h00);
    wr(1'b0, 8'h20);
  endtask

  task automatic t_lock();
    ch_run = 1'b1;
    wr(1'b1, 8'hFF);
    check("R3 hi locked", {8'd0, mode_rd[15:8]}, 16'h0000);
    wr(1'b0, 8'h47);
    check("R3 lo locked / R11 bit0 set", {8'd0, mode_rd[7:0]}, 16'h0021);
    wr(1'b0, 8'h00);
    check("R11 bit0 cleared", {8'd0, mode_rd[7:0]}, 16'h0020);
    ch_run = 1'b0;
    tick();
  endtask

  task automatic t_divider();
    int cnt = 0;
    int first = -1;
    div_ratio = 7'd2; pre_ce0 = 1'b1; pre_ce1 = 1'b0;
    wr(1'b1, 8'h00);
    for (int i = 0; i < 10; i++) begin
      #1; if (tclk_ce) cnt++;
      tick();
    end
    check("R5 idle no tclk", 16'(cnt), 16'd0);
    ch_run = 1'b1;
    for (int i = 0; i < 24; i++) begin
      #1;
      if (tclk_ce) begin cnt++; if (first < 0) first = i; end
      tick();
    end
    check("R5 pulse count", 16'(cnt), 16'd4);
    check("R5 first pulse", 16'(first), 16'd5);
    ch_run = 1'b0;
    tick();
  endtask

  task automatic t_opclk();
    int cnt = 0;
    int bad = 0;
    div_ratio = 7'd0; pre_ce0 = 1'b1; pre_ce1 = 1'b0;
    wr(1'b1, 8'h80);
    ch_run = 1'b1;
    for (int i = 0; i < 12; i++) begin
      #1; if (tclk_ce) cnt++;
      tick();
    end
    check("R4 ce0 ignored", 16'(cnt), 16'd0);
    ch_run = 1'b0;
    tick();
    ch_run = 1'b1;
    for (int i = 0; i < 16; i++) begin
      pre_ce1 = i[0];
      #1;
      if (tclk_ce) begin cnt++; if (!pre_ce1) bad++; end
      tick();
    end
    check("R4 ce1 pulses", 16'(cnt), 16'd4);
    check("R4 aligned to ce1", 16'(bad), 16'd0);
    pre_ce1 = 1'b0; ch_run = 1'b0;
    tick();
  endtask

  task automatic t_external();
    int cnt = 0;
    pre_ce0 = 1'b1;
    wr(1'b1, 8'h40);
    ch_run = 1'b1;
    for (int k = 0; k < 3; k++) begin
      sck_in = 1'b1;
      tick(); #1; check("R6 after 1 edge", {15'd0, tclk_ce}, 16'd0);
      tick(); #1; check("R6 after 2 edges", {15'd0, tclk_ce}, 16'd1);
      if (tclk_ce) cnt++;
      tick(); #1; check("R6 single pulse", {15'd0, tclk_ce}, 16'd0);
      sck_in = 1'b0;
      for (int j = 0; j < 3; j++) begin
        tick(); #1; if (tclk_ce) cnt++;
      end
    end
    check("R6 rising edges only", 16'(cnt), 16'd3);
    ch_run = 1'b0;
    tick();
  endtask

  task automatic t_soft_trig();
    wr(1'b1, 8'h00);
    ch_run = 1'b1;
    tick();
    start_req = 1'b1;
    tick(); start_req = 1'b0;
    check("R7 not yet", {15'd0, start_pulse}, 16'd0);
    tick(); check("R7 pulse", {15'd0, start_pulse}, 16'd1);
    tick(); check("R7 one cycle", {15'd0, start_pulse}, 16'd0);
    ch_run = 1'b0;
    tick();
    start_req = 1'b1;
    tick(); start_req = 1'b0;
    for (int i = 0; i < 3; i++) begin
      tick(); check("R7 stopped request ignored", {15'd0, start_pulse}, 16'd0);
    end
    ch_run = 1'b1;
    for (int i = 0; i < 3; i++) begin
      tick(); check("R7 no stale request", {15'd0, start_pulse}, 16'd0);
    end
    ch_run = 1'b0;
    tick();
  endtask

  task automatic t_edge_trig();
    rxd_in = 1'b1;
    wr(1'b1, 8'h01);
    wr(1'b0, 8'h22);
    ch_run = 1'b1;
    tick();
    start_req = 1'b1;
    tick(); start_req = 1'b0;
    for (int i = 0; i < 4; i++) begin
      tick(); check("R8 waits for edge", {15'd0, start_pulse}, 16'd0);
    end
    rxd_in = 1'b0;
    tick(); check("R8 edge+1", {15'd0, start_pulse}, 16'd0);
    tick(); check("R8 edge+2", {15'd0, start_pulse}, 16'd0);
    tick(); check("R8 edge+3 pulse", {15'd0, start_pulse}, 16'd1);
    tick(); check("R8 one cycle", {15'd0, start_pulse}, 16'd0);
    rxd_in = 1'b1;
    repeat (3) tick();
    // edge seen in the cycle the request is sampled
    rxd_in = 1'b0;
    tick(); tick();
    start_req = 1'b1;
    tick(); start_req = 1'b0;
    check("R8 same-cycle edge", {15'd0, start_pulse}, 16'd0);
    for (int i = 0; i < 4; i++) begin
      tick(); check("R8 same-cycle edge ignored", {15'd0, start_pulse}, 16'd0);
    end
    rxd_in = 1'b1;
    for (int i = 0; i < 3; i++) begin
      tick(); check("R8 rising edge no start", {15'd0, start_pulse}, 16'd0);
    end
    rxd_in = 1'b0;
    tick(); tick();
    tick(); check("R8 later edge starts", {15'd0, start_pulse}, 16'd1);
    tick();
    rxd_in = 1'b1;
    repeat (3) tick();
    // R9: stop clears armed state
    start_req = 1'b1;
    tick(); start_req = 1'b0;
    ch_run = 1'b0;
    tick();
    ch_run = 1'b1;
    tick();
    rxd_in = 1'b0;
    for (int i = 0; i < 4; i++) begin
      tick(); check("R9 disarmed by stop", {15'd0, start_pulse}, 16'd0);
    end
    rxd_in = 1'b1;
    repeat (3) tick();
    ch_run = 1'b0;
    tick();
  endtask

  task automatic t_invert();
    rxd_in = 1'b1;
    wr(1'b0, 8'h42);
    #1; check("R10 async inverted high", {15'd0, rxd_out}, 16'd0);
    rxd_in = 1'b0;
    tick(); #1; check("R10 sync latency", {15'd0, rxd_out}, 16'd0);
    tick(); #1; check("R10 async inverted low", {15'd0, rxd_out}, 16'd1);
    wr(1'b0, 8'h40);
    #1; check("R10 sync mode not inverted", {15'd0, rxd_out}, 16'd0);
    wr(1'b0, 8'h44);
    #1; check("R10 two-wire not inverted", {15'd0, rxd_out}, 16'd0);
    // R12: inverted edge trigger
    wr(1'b1, 8'h01);
    wr(1'b0, 8'h42);
    repeat (3) tick();
    ch_run = 1'b1;
    tick();
    start_req = 1'b1;
    tick(); start_req = 1'b0;
    tick(); check("R12 idle", {15'd0, start_pulse}, 16'd0);
    rxd_in = 1'b1;
    tick(); tick();
    tick(); check("R12 pin rise starts", {15'd0, start_pulse}, 16'd1);
    tick(); check("R12 one cycle", {15'd0, start_pulse}, 16'd0);
    ch_run = 1'b0;
    tick();
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      report();
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_hi = 1'b0; wr_data = 8'h00; div_ratio = 7'd0;
    ch_run = 1'b0; start_req = 1'b0; pre_ce0 = 1'b0; pre_ce1 = 1'b0;
    sck_in = 1'b0; rxd_in = 1'b1;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();
    t_reset();
    t_reserved();
    t_lock();
    t_divider();
    t_opclk();
    t_external();
    t_soft_trig();
    t_edge_trig();
    t_invert();
    done = 1'b1;
    report();
  end

endmodule